// File: doc/BRIEF.md
# Flash Chip-Enable Select Controller

This block drives the active-low chip-enable lines of up to four flash memory devices that share one bus. A command sequencer sends it start and done pulses for each command. Software sends it device-select requests that carry a device index. A separate write port sets or clears a sticky hold bit. While the hold bit is set, the enable of the selected device stays low between commands. When another device is selected, the low enable moves to that device.

Each select request is checked against the current configuration before it is accepted. The configuration is a device-count field plus a flag that says whether a removable card slot uses the top index. A request with an illegal index changes nothing. It raises an error flag for one cycle.

Top module: `ce_select_ctrl`

## Requirements
- R1: After reset all `ce_n` lines are high, `sel_err` is low, the hold bit is clear and the selected index is 0. The first `cmd_start` after reset therefore drives `ce_n` = 4'b1110.
- R2: One cycle after `cmd_start`, the line of the selected device is low. Bit i of `ce_n` belongs to device i.
- R3: One cycle after `cmd_done`, all lines are high, provided the hold bit is clear after that edge and no `cmd_start` occurs in the same cycle.
- R4: Writing the hold bit to 1 (`hold_we`=1, `hold_d`=1) drives the selected line low on the next cycle. While the bit stays set, the line remains low through `cmd_done`.
- R5: An accepted select moves an asserted enable to the new device one cycle later. In that cycle the old line goes high and the new line goes low. When no enable is asserted, a select leaves all lines high.
- R6: Writing the hold bit to 0 does not by itself raise an asserted line.
- R7: With the card slot disabled (`card_en`=0) and a count field N, the legal indices are 0 through N.
- R8: With the card slot enabled, index 3 is always legal, and so is any index below N. With N=0, only index 3 is legal.
- R9: A select with an illegal index is ignored: the selection is kept and `sel_err` is high for exactly the next cycle.
- R10: At most one `ce_n` line is low at any time.
- R11: When `cmd_start` and `cmd_done` arrive in the same cycle, start wins and the selected line is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_req | input | 1 | Device-select request strobe |
| sel_idx | input | 2 | Requested device index |
| hold_we | input | 1 | Write strobe for the hold bit |
| hold_d | input | 1 | Value written to the hold bit |
| cmd_start | input | 1 | Command begins executing (pulse) |
| cmd_done | input | 1 | Command finished (pulse) |
| dev_count | input | 2 | Configured device-count field N |
| card_en | input | 1 | Card slot occupies index 3 |
| ce_n | output | 4 | Active-low chip enables, one per device |
| sel_err | output | 1 | One-cycle flag for a rejected select |

## Verification
The assertions check several properties on every cycle:
- that no more than one enable is low;
- that a set hold bit always keeps an enable asserted;
- that a start pulse yields a low line and an unheld done yields all lines high;
- that clearing the hold bit never lowers the count of asserted lines;
- that a rejected select keeps the selection and raises the flag.

Only the bench scenarios can show the full legality tables for each count and card setting. The same holds for the exact line that goes low after a handover, the start-over-done priority, and the reset selection of device 0. The bench compares these against its own reference model.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int DEV_W_DEF = 2;

  // Enable-line events seen in one cycle
  typedef struct packed {
    logic start;
    logic done;
    logic hold_we;
    logic hold_d;
  } ce_evt_t;
endpackage

// File: rtl/ce_idx_check.sv
module ce_idx_check #(
  parameter int DEV_W = 2
) (
  input  logic [DEV_W-1:0] idx,
  input  logic [DEV_W-1:0] count,
  input  logic             card_en,
  output logic             ok
);
  localparam int NUM_DEV = 1 << DEV_W;
  localparam logic [DEV_W-1:0] CARD_IDX = DEV_W'(NUM_DEV - 1);

  // With the card slot on, the top index is the card and flash devices are
  // the indices below the count; otherwise flash devices are 0..count.
  function automatic logic idx_legal(input logic [DEV_W-1:0] i,
                                     input logic [DEV_W-1:0] n,
                                     input logic card);
    if (card) return (i == CARD_IDX) || (i < n);
    return i <= n;
  endfunction

  assign ok = idx_legal(idx, count, card_en);
endmodule

// File: rtl/ce_sel_reg.sv
module ce_sel_reg #(
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DEV_W-1:0] idx,
  input  logic             idx_ok,
  output logic [DEV_W-1:0] sel_q,
  output logic             err_q
);
  logic accept;
  logic reject;

  assign accept = req && idx_ok;
  assign reject = req && !idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (accept) sel_q <= idx;
      err_q <= reject;
    end
  end

  // R9: rejected request keeps the selection and flags once
  p_reject_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_q && $stable(sel_q)));
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(reject));
endmodule

// File: rtl/ce_hold_state.sv
module ce_hold_state
  import ce_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ce_evt_t evt,
  output logic    hold_q,
  output logic    on_q
);
  logic hold_nxt;
  logic hold_set;

  assign hold_nxt = evt.hold_we ? evt.hold_d : hold_q;
  assign hold_set = evt.hold_we && evt.hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      on_q   <= 1'b0;
    end else begin
      hold_q <= hold_nxt;
      if (evt.start || hold_set) on_q <= 1'b1;      // start has priority (R11)
      else if (evt.done)         on_q <= hold_nxt;  // held line survives done
    end
  end

  // R4: a set hold bit always keeps the enable asserted
  p_hold_keeps_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> on_q);
  // R11: start wins over a simultaneous done
  p_start_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.start && evt.done) |=> on_q);
endmodule

// File: rtl/ce_line_drv.sv
module ce_line_drv #(
  parameter int DEV_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     on,
  input  logic [DEV_W-1:0]         sel,
  output logic [(1<<DEV_W)-1:0]    ce_n
);
  localparam int NUM_DEV = 1 << DEV_W;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_line
    assign ce_n[d] = !(on && (sel == DEV_W'(d)));
  end

  // R10: never two devices enabled together
  p_single_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
endmodule

// File: rtl/ce_select_ctrl.sv
module ce_select_ctrl
  import ce_pkg::*;
#(
  parameter int DEV_W = ce_pkg::DEV_W_DEF,
  localparam int NUM_DEV = 1 << DEV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_req,
  input  logic [DEV_W-1:0]   sel_idx,
  input  logic               hold_we,
  input  logic               hold_d,
  input  logic               cmd_start,
  input  logic               cmd_done,
  input  logic [DEV_W-1:0]   dev_count,
  input  logic               card_en,
  output logic [NUM_DEV-1:0] ce_n,
  output logic               sel_err
);
  logic             idx_ok;
  logic [DEV_W-1:0] sel_q;
  logic             hold_q;
  logic             on_q;
  ce_evt_t          evt;

  assign evt = '{start: cmd_start, done: cmd_done, hold_we: hold_we, hold_d: hold_d};

  ce_idx_check #(.DEV_W(DEV_W)) u_chk (
    .idx(sel_idx), .count(dev_count), .card_en(card_en), .ok(idx_ok));

  ce_sel_reg #(.DEV_W(DEV_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(sel_req), .idx(sel_idx),
    .idx_ok(idx_ok), .sel_q(sel_q), .err_q(sel_err));

  ce_hold_state u_hold (
    .clk(clk), .rst_n(rst_n), .evt(evt), .hold_q(hold_q), .on_q(on_q));

  ce_line_drv #(.DEV_W(DEV_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .on(on_q), .sel(sel_q), .ce_n(ce_n));

  // R2: a starting command enables a device
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !(&ce_n));
  // R3: an unheld completion releases every line
  p_done_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cmd_start && ((hold_we && !hold_d) || (!hold_we && !hold_q)))
    |=> (&ce_n));
  // R6: clearing the hold bit alone never raises an asserted line
  p_clear_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && !hold_d && !cmd_done && !cmd_start)
    |=> ($countones(~ce_n) == $past($countones(~ce_n))));
endmodule

// File: tb/tb_ce_select_ctrl.sv
module tb_ce_select_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_req = 1'b0;
  logic [1:0] sel_idx = '0;
  logic       hold_we = 1'b0;
  logic       hold_d = 1'b0;
  logic       cmd_start = 1'b0;
  logic       cmd_done = 1'b0;
  logic [1:0] dev_count = 2'd3;
  logic       card_en = 1'b0;
  logic [3:0] ce_n;
  logic       sel_err;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  // reference state
  logic [1:0] m_sel = '0;
  logic       m_on = 1'b0;
  logic       m_hold = 1'b0;
  logic       m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ce_select_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_idx(sel_idx),
    .hold_we(hold_we), .hold_d(hold_d), .cmd_start(cmd_start),
    .cmd_done(cmd_done), .dev_count(dev_count), .card_en(card_en),
    .ce_n(ce_n), .sel_err(sel_err));

  // legal set as a bit mask over indices
  function automatic logic legal_ref(input logic [1:0] i, input logic [1:0] n,
                                     input logic card);
    logic [4:0] mask;
    if (card) mask = ((5'd1 << n) - 5'd1) | 5'b01000;
    else      mask = (5'd2 << n) - 5'd1;
    return mask[i];
  endfunction

  function automatic logic [3:0] ce_ref(input logic on, input logic [1:0] s);
    return on ? ~(4'b0001 << s) : 4'b1111;
  endfunction

  task automatic check(input string tag);
    logic [3:0] exp_ce;
    exp_ce = ce_ref(m_on, m_sel);
    checks++;
    if (ce_n !== exp_ce || sel_err !== m_err || $countones(~ce_n) > 1) begin
      fails++;
      $display("FAIL %s: ce_n=%b sel_err=%b expected ce_n=%b sel_err=%b",
               tag, ce_n, sel_err, exp_ce, m_err);
    end
  endtask

  // apply inputs (already set at negedge), clock once, update model, check
  task automatic step(input string tag);
    logic hn;
    logic ok;
    @(posedge clk);
    ok = legal_ref(sel_idx, dev_count, card_en);
    hn = hold_we ? hold_d : m_hold;
    if (cmd_start || (hold_we && hold_d)) m_on = 1'b1;
    else if (cmd_done) m_on = hn;
    m_hold = hn;
    if (sel_req && ok) m_sel = sel_idx;
    m_err = sel_req && !ok;
    @(negedge clk);
    check(tag);
    sel_req = 0; hold_we = 0; hold_d = 0; cmd_start = 0; cmd_done = 0;
  endtask

  task automatic sel(input logic [1:0] i, input string tag);
    sel_req = 1; sel_idx = i; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state");
    cmd_start = 1; step("R1 R2 start after reset selects device 0");
    cmd_done = 1;  step("R3 done releases lines");
    // card off, N=3
    dev_count = 2'd3; card_en = 0;
    sel(2'd2, "R5 select while idle keeps lines high");
    cmd_start = 1; step("R2 start drives device 2");
    sel(2'd1, "R5 handover during command");
    cmd_done = 1;  step("R3 done after handover");
    hold_we = 1; hold_d = 1; step("R4 hold set asserts line");
    cmd_done = 1;  step("R4 held line survives done");
    sel(2'd3, "R5 R7 handover to index 3 with N=3");
    hold_we = 1; hold_d = 0; step("R6 clearing hold keeps line low");
    cmd_done = 1;  step("R3 done after hold cleared");
    // card on, N=1: legal {0,3}
    card_en = 1; dev_count = 2'd1;
    sel(2'd2, "R8 R9 index 2 illegal with card and N=1");
    cmd_start = 1; step("R9 selection kept after reject");
    cmd_done = 1;  step("R3 release");
    cmd_start = 1; cmd_done = 1; step("R11 start wins over done");
    sel(2'd0, "R8 index 0 legal with card and N=1");
    sel(2'd1, "R8 index 1 illegal with card and N=1");
    cmd_done = 1;  step("R3 release");
    dev_count = 2'd0;
    sel(2'd0, "R8 N=0 with card rejects index 0");
    sel(2'd3, "R8 N=0 with card accepts card index");
    // card off, N=0: legal {0}
    card_en = 0;
    sel(2'd1, "R7 index 1 illegal with N=0");
    sel(2'd0, "R7 index 0 legal with N=0");
    // random mix
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 15) == 0) begin
        dev_count = 2'($urandom_range(0, 3));
        card_en = 1'($urandom_range(0, 1));
      end
      sel_req   = ($urandom_range(0, 3) == 0);
      sel_idx   = 2'($urandom_range(0, 3));
      hold_we   = ($urandom_range(0, 7) == 0);
      hold_d    = 1'($urandom_range(0, 1));
      cmd_start = ($urandom_range(0, 5) == 0);
      cmd_done  = ($urandom_range(0, 4) == 0);
      step("R5 R9 R10 random traffic");
    end
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule